// File: doc/BRIEF.md
# Prioritised Address Window Translator

This block turns a 32-bit local bus address into a downstream bus address and a cycle type. It uses three programmable windows. Windows 0 and 1 are memory windows whose size is a power of two from 1 MB to 2 GB. Window 2 is a fixed 16 MB I/O window. A simple write port loads the six window registers, which are one base register and one map register per window.

Each request cycle yields a registered response one clock later. The response carries a hit or miss flag, the index of the window that won, the translated address, a 3-bit cycle type and a prefetch flag. Windows may overlap, and the lowest index always wins. Software depends on this. It can enlarge window 0 so that it covers the range of window 1. It can then reprogram window 1 for some other purpose, for example configuration cycles, and no access is routed through window 1 while the change is in progress.

Top module: `win_xlat_top`

## Requirements
- R1: After reset every window register reads as zero, so every window is disabled. rsp_valid_o is 0, all response fields are 0, and any request misses.
- R2: A write with cfg_we_i=1 loads cfg_wdata_i into a register chosen by cfg_sel_i: 0=window 0 base, 1=window 0 map, 2=window 1 base, 3=window 1 map, 4=window 2 base, 5=window 2 map. Map registers keep bits 15:0. Codes 6 and 7 have no effect. A write takes effect for requests issued in the following cycle, not for a request issued in the same cycle.
- R3: The base register of a memory window holds the address bits 31:20 in its bits 31:20, the size code in bits 7:4, prefetchable in bit 3 and enable in bit 0. Size code n gives a window of 1 MB << n. Codes 12 to 15 act as 11 (2 GB). Base bits below the window size are ignored.
- R4: An address hits an enabled memory window when it lies in the naturally aligned range of the window size that contains the base. Both range edges are inclusive of the first byte and exclusive of the byte past the end.
- R5: When several enabled windows match, the lowest-numbered window wins. rsp_win_o gives its index (0, 1 or 2).
- R6: For a memory hit, the translated address takes the map bits above the window size and the local address bits below it. The map register holds the translated bits 31:20 in its bits 15:4.
- R7: For a memory hit, rsp_cyc_o equals map bits 3:1 (000 interrupt acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple), and rsp_pref_o equals base bit 3.
- R8: When map bit 0 of a memory window is 0, rsp_addr_o[1:0] is forced to 0. When it is 1, those bits come from the local address.
- R9: Window 2 compares address bits 31:24 against its base bits 15:8, with enable at base bit 0. It replaces bits 31:24 with map bits 15:8 and passes bits 23:0 through unchanged. Its cycle type is 001 and its prefetch flag is 0.
- R10: A request that matches no enabled window returns rsp_hit_o=0 and rsp_miss_o=1, with rsp_win_o, rsp_addr_o, rsp_cyc_o and rsp_pref_o all 0.
- R11: rsp_valid_o equals req_valid_i of the previous cycle. When rsp_valid_o is 0, every other response output is 0.
- R12: If window 0 is enlarged to cover the range of window 1, addresses in that range translate through window 0 while window 1 is being reprogrammed. They still do so after window 1 has been moved to a new range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| req_valid_i | input | 1 | Translation request valid |
| req_addr_i | input | 32 | Local bus address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_hit_o | output | 1 | An enabled window matched |
| rsp_miss_o | output | 1 | No enabled window matched |
| rsp_win_o | output | 2 | Index of the winning window |
| rsp_addr_o | output | 32 | Translated address |
| rsp_cyc_o | output | 3 | Cycle type code |
| rsp_pref_o | output | 1 | Winning window is prefetchable |

## Verification
The assertions rely on two things about the inputs: req_valid_i and cfg_we_i are low while reset is asserted, and cfg_sel_i is known whenever a write is strobed. Every value of req_addr_i and cfg_wdata_i is legal, including size codes above 11 and stray bits below the window size. The stimulus drives inputs only on the falling edge and holds both strobes low during reset. It mixes directed layouts with random writes and with addresses biased toward programmed bases, so that overlaps, exact edges and clamped sizes are all reached.

// File: rtl/win_xlat_pkg.sv
package win_xlat_pkg;
  localparam int AW = 32;

  typedef enum logic [2:0] {
    CYC_IACK = 3'b000,
    CYC_IO   = 3'b001,
    CYC_MEM  = 3'b011,
    CYC_CFG  = 3'b101,
    CYC_MEMM = 3'b110
  } cyc_e;

  typedef struct packed {
    logic          hit;
    logic [AW-1:0] addr;
    logic [2:0]    cyc;
    logic          pref;
  } win_res_t;
endpackage

// File: rtl/win_regs.sv
module win_regs #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 3,
  parameter int MAP_W   = 16,
  localparam int SEL_W  = $clog2(2*NUM_WIN)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [ADDR_W-1:0]               wdata_i,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]  base_o,
  output logic [NUM_WIN-1:0][MAP_W-1:0]   map_o
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[w] <= '0;
        map_o[w]  <= '0;
      end else if (we_i) begin
        if (sel_i == SEL_W'(2*w))   base_o[w] <= wdata_i;
        if (sel_i == SEL_W'(2*w+1)) map_o[w]  <= wdata_i[MAP_W-1:0];
      end
    end
  end

  a_r2_base0_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && sel_i == '0 |=> base_o[0] == $past(wdata_i));
  a_r2_base0_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(base_o) && $stable(map_o));
endmodule

// File: rtl/win_mem_match.sv
module win_mem_match
  import win_xlat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 20,
  parameter int SIZE_MAX = 11,
  parameter int MAP_W    = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [MAP_W-1:0]  map_i,
  output win_res_t          res_o
);
  localparam int LSB_W = $clog2(ADDR_W) + 1;

  logic [3:0]        size_code, eff_code;
  logic [LSB_W-1:0]  lsb;
  logic [ADDR_W-1:0] hi_mask, map_full, xa;

  always_comb begin
    size_code = base_i[7:4];
    eff_code  = (size_code > 4'(SIZE_MAX)) ? 4'(SIZE_MAX) : size_code;
    lsb       = LSB_W'(GRAN_LSB) + LSB_W'(eff_code);
    hi_mask   = {ADDR_W{1'b1}} << lsb;
    map_full  = {map_i[MAP_W-1:4], {GRAN_LSB{1'b0}}};
    xa        = (map_full & hi_mask) | (addr_i & ~hi_mask);
    if (!map_i[0]) xa[1:0] = 2'b00;
    res_o.hit  = base_i[0] && (((addr_i ^ base_i) & hi_mask) == '0);
    res_o.addr = xa;
    res_o.cyc  = map_i[3:1];
    res_o.pref = base_i[3];
  end
endmodule

// File: rtl/win_io_match.sv
module win_io_match
  import win_xlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IO_LSB = 24,
  parameter int MAP_W  = 16,
  localparam int TAG_W = ADDR_W - IO_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [MAP_W-1:0]  map_i,
  output win_res_t          res_o
);
  always_comb begin
    res_o.hit  = base_i[0] && (addr_i[ADDR_W-1:IO_LSB] == base_i[MAP_W-1 -: TAG_W]);
    res_o.addr = {map_i[MAP_W-1 -: TAG_W], addr_i[IO_LSB-1:0]};
    res_o.cyc  = CYC_IO;
    res_o.pref = 1'b0;
  end
endmodule

// File: rtl/win_prio.sv
module win_prio
  import win_xlat_pkg::*;
#(
  parameter int NUM_WIN = 3,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  win_res_t [NUM_WIN-1:0] res_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o,
  output win_res_t               sel_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    sel_o = '0;
    // descending scan so the lowest index is applied last
    for (int w = NUM_WIN-1; w >= 0; w--) begin
      if (res_i[w].hit) begin
        any_o = 1'b1;
        idx_o = IDX_W'(w);
        sel_o = res_i[w];
      end
    end
  end
endmodule

// File: rtl/win_xlat_top.sv
module win_xlat_top
  import win_xlat_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MEM_WIN  = 2,
  parameter int GRAN_LSB = 20,
  parameter int SIZE_MAX = 11,
  parameter int IO_LSB   = 24,
  localparam int NUM_WIN = MEM_WIN + 1,
  localparam int MAP_W   = 16,
  localparam int SEL_W   = $clog2(2*NUM_WIN),
  localparam int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_miss_o,
  output logic [IDX_W-1:0]  rsp_win_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [2:0]        rsp_cyc_o,
  output logic              rsp_pref_o
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] base;
  logic [NUM_WIN-1:0][MAP_W-1:0]  map;
  win_res_t [NUM_WIN-1:0]         res;
  win_res_t                       win_sel;
  logic                           any_hit;
  logic [IDX_W-1:0]               win_idx;

  win_regs #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .MAP_W(MAP_W)) i_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .base_o(base), .map_o(map)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    if (w < MEM_WIN) begin : g_mem
      win_mem_match #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .SIZE_MAX(SIZE_MAX),
                      .MAP_W(MAP_W)) i_match (
        .addr_i(req_addr_i), .base_i(base[w]), .map_i(map[w]), .res_o(res[w]));
    end else begin : g_io
      win_io_match #(.ADDR_W(ADDR_W), .IO_LSB(IO_LSB), .MAP_W(MAP_W)) i_match (
        .addr_i(req_addr_i), .base_i(base[w]), .map_i(map[w]), .res_o(res[w]));
    end
  end

  win_prio #(.NUM_WIN(NUM_WIN)) i_prio (
    .res_i(res), .any_o(any_hit), .idx_o(win_idx), .sel_o(win_sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_win_o   <= '0;
      rsp_addr_o  <= '0;
      rsp_cyc_o   <= '0;
      rsp_pref_o  <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_hit_o   <= req_valid_i && any_hit;
      rsp_miss_o  <= req_valid_i && !any_hit;
      rsp_win_o   <= (req_valid_i && any_hit) ? win_idx : '0;
      rsp_addr_o  <= (req_valid_i && any_hit) ? win_sel.addr : '0;
      rsp_cyc_o   <= (req_valid_i && any_hit) ? win_sel.cyc : '0;
      rsp_pref_o  <= req_valid_i && any_hit && win_sel.pref;
    end
  end

  a_r5_win0_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && res[0].hit |=> rsp_hit_o && rsp_win_o == '0);
  a_r8_low_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && res[0].hit && !map[0][0] |=> rsp_addr_o[1:0] == 2'b00);
  a_r9_io_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o && rsp_win_o == IDX_W'(MEM_WIN)
      |-> rsp_cyc_o == CYC_IO && !rsp_pref_o);
  a_r10_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_miss_o |-> rsp_addr_o == '0 && rsp_cyc_o == '0 && !rsp_pref_o && rsp_win_o == '0);
  a_r10_hit_xor_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_hit_o ^ rsp_miss_o));
  a_r11_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_hit_o && !rsp_miss_o && rsp_addr_o == '0);
endmodule

// File: tb/test_win_xlat_top.sv
module test_win_xlat_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_pref;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_cyc;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mb [3];
  logic [15:0] mm [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  win_xlat_top i_win_xlat_top (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_win_o(rsp_win), .rsp_addr_o(rsp_addr), .rsp_cyc_o(rsp_cyc),
    .rsp_pref_o(rsp_pref)
  );

  // {valid, hit, miss, win, addr, cyc, pref}
  function automatic logic [40:0] model(input bit v, input logic [31:0] a);
    longint unsigned la, lo, sz, mbase, xa;
    int n;
    if (!v) return '0;
    la = 64'(a);
    for (int w = 0; w < 3; w++) begin
      if (w < 2) begin
        n = int'(mb[w][7:4]);
        if (n > 11) n = 11;
        sz = 64'd1 << (20 + n);
        lo = 64'(mb[w]) & ~(sz - 1);
        if (mb[w][0] && la >= lo && la < lo + sz) begin
          mbase = 64'({mm[w][15:4], 20'h0}) & ~(sz - 1);
          xa = mbase + (la - lo);
          if (!mm[w][0]) xa = xa & ~64'd3;
          return {1'b1, 1'b1, 1'b0, 2'(w), xa[31:0], mm[w][3:1], mb[w][3]};
        end
      end else begin
        sz = 64'd1 << 24;
        lo = 64'({mb[2][15:8], 24'h0});
        if (mb[2][0] && la >= lo && la < lo + sz) begin
          xa = 64'({mm[2][15:8], 24'h0}) + (la - lo);
          return {1'b1, 1'b1, 1'b0, 2'd2, xa[31:0], 3'b001, 1'b0};
        end
      end
    end
    return {1'b1, 1'b0, 1'b1, 2'd0, 32'h0, 3'b000, 1'b0};
  endfunction

  function automatic string pick_tag(input logic [40:0] e);
    if (!e[40]) return "R11";
    if (e[38]) return "R10";
    if (e[37:36] == 2'd2) return "R9";
    return "R6";
  endfunction

  task automatic compare(input logic [40:0] exp_v, input string tag);
    logic [40:0] act;
    act = {rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_addr, rsp_cyc, rsp_pref};
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // called just after a falling edge; drives, then checks one cycle later
  task automatic step(input bit v, input logic [31:0] a, input bit we,
                      input logic [2:0] sel, input logic [31:0] d, input string tag);
    logic [40:0] e;
    req_valid = v; req_addr = a; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    e = model(v, a);
    if (we) begin
      if (sel < 3'd6) begin
        if (sel[0]) mm[sel >> 1] = d[15:0];
        else        mb[sel >> 1] = d;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(e, (tag == "") ? pick_tag(e) : tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    step(1'b0, 32'h0, 1'b1, sel, d, "R2");
  endtask

  task automatic rq(input logic [31:0] a, input string tag);
    step(1'b1, a, 1'b0, 3'd0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 3; w++) begin mb[w] = '0; mm[w] = '0; end
    repeat (3) @(negedge clk);
    compare('0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    rq(32'h4000_0000, "R1");
    rq(32'h6000_0000, "R1");

    // window 0: 256 MB at 0x4000_0000 -> 0x8000_0000, memory type
    wr(3'd0, 32'h4000_0081);
    // same-cycle write is not visible to the request
    step(1'b1, 32'h4123_4567, 1'b1, 3'd1, 32'h0000_8006, "R2");
    rq(32'h4123_4567, "R8");
    wr(3'd1, 32'h0000_8007);
    rq(32'h4123_4567, "R8");
    rq(32'h4000_0000, "R4");
    rq(32'h4FFF_FFFF, "R4");
    rq(32'h3FFF_FFFF, "R4");
    // window 1: 256 MB prefetchable at 0x5000_0000 -> 0x9000_0000
    wr(3'd2, 32'h5000_0089);
    wr(3'd3, 32'h0000_9006);
    rq(32'h5000_0010, "R7");
    rq(32'h5FFF_FFFF, "R4");
    rq(32'h6000_0000, "R10");
    // window 2: I/O 0x60xx_xxxx -> 0x12xx_xxxx
    wr(3'd4, 32'h0000_6001);
    wr(3'd5, 32'h0000_1200);
    rq(32'h60AB_CDEF, "R9");
    rq(32'h6100_0000, "R9");
    // unused select codes
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rq(32'h4123_4567, "R2");
    rq(32'h5000_0010, "R2");
    // idle cycle
    step(1'b0, 32'h4123_4567, 1'b0, 3'd0, 32'h0, "R11");
    // enlarge window 0 to 512 MB, then move window 1 to config at 0x6100_0000
    wr(3'd0, 32'h4000_0091);
    rq(32'h5000_0010, "R12");
    wr(3'd2, 32'h6100_0041);
    rq(32'h5000_0010, "R12");
    wr(3'd3, 32'h0000_000A);
    rq(32'h5000_0010, "R12");
    rq(32'h6100_0103, "R7");
    // restore window 1 then shrink window 0
    wr(3'd2, 32'h5000_0089);
    wr(3'd3, 32'h0000_9006);
    wr(3'd0, 32'h4000_0081);
    rq(32'h5000_0010, "R12");
    // overlap of window 0 and window 2
    wr(3'd4, 32'h0000_4001);
    rq(32'h4000_0100, "R5");
    wr(3'd0, 32'h0000_0000);
    rq(32'h4000_0100, "R5");
    // stray base bits below size, size clamp, 1 MB size
    wr(3'd4, 32'h0000_0000);
    wr(3'd2, 32'h0000_0000);
    wr(3'd0, 32'h4567_8081);
    rq(32'h4000_0004, "R3");
    rq(32'h4FFF_FFFC, "R3");
    wr(3'd0, 32'h0000_00F1);
    rq(32'h7FFF_FFFF, "R3");
    rq(32'h8000_0000, "R3");
    wr(3'd0, 32'h7F30_0001);
    rq(32'h7F3F_FFFF, "R3");
    rq(32'h7F40_0000, "R3");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit v, we;
      logic [2:0] sel;
      logic [31:0] d, a;
      int w;
      we = ($urandom_range(0, 9) < 3);
      sel = 3'($urandom_range(0, 7));
      d = $urandom;
      v = ($urandom_range(0, 9) < 8);
      w = $urandom_range(0, 2);
      case ($urandom_range(0, 3))
        0: a = $urandom;
        1: a = mb[w] + 32'($urandom_range(0, 4095));
        2: a = {mb[w][15:8], 24'h0} + 32'($urandom_range(0, 16777215));
        default: a = (mb[w] & 32'hFFF0_0000) - 32'($urandom_range(1, 8));
      endcase
      step(v, a, we, sel, d, "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule